// File: doc/BRIEF.md
# FP8 to single-precision widening decoder

This block widens one 8-bit floating-point code into the IEEE-754 single-precision word of the same value. One input bit picks the layout of the byte. With that bit clear, the byte holds a sign bit, a 4-bit exponent with bias 7 and a 3-bit fraction. With it set, the byte holds a sign bit, a 5-bit exponent with bias 15 and a 2-bit fraction. The wider-exponent layout covers twice the exponent field range but has half as many fraction steps in each binade.

Every finite code maps exactly into single precision. Subnormal codes become single-precision normals: the leading one of the fraction is located, the fraction is shifted past it, and the exponent is lowered by the same amount. Zeros keep their sign. Each layout has its own special codes, and these map to a canonical quiet NaN or to infinity. The result and its valid flag are registered together, one clock after the input strobe.

Top module: `f8x_widen`

## Requirements
- R1: With in_fmt=0, a code with exponent field e (bits 6:3, 1..15) and fraction f (bits 2:0) that is not a special code yields exponent e+120 and fraction {f,20'b0}. For example, 0x38 gives 0x3F800000 and 0x78 gives 0x43800000.
- R2: With in_fmt=1, a code with exponent field e (bits 6:2, 1..30) and fraction f (bits 1:0) yields exponent e+112 and fraction {f,21'b0}. For example, 0x3C gives 0x3F800000 and 0x04 gives 0x38800000.
- R3: The largest finite codes decode exactly. In mode 0, 0x7E gives 448 (0x43E00000) and 0xFE gives -448. In mode 1, 0x7B gives 57344 (0x47600000) and 0xFB gives -57344.
- R4: Subnormal codes (exponent field zero, fraction nonzero) are normalized into single-precision normals. Mode 0 code 0x01 gives 2^-9 (0x3B000000) and mode 1 code 0x01 gives 2^-16 (0x37800000).
- R5: Codes 0x00 and 0x80 give 0x00000000 and 0x80000000 in both modes.
- R6: In mode 0, only codes with bits 6:0 all ones give a quiet NaN {sign, 8'hFF, 1'b1, 22'b0}. The other codes with exponent field 1111 are normals: 0x7C gives 384 (0x43C00000).
- R7: In mode 1, exponent field 11111 with fraction 00 gives infinity {sign, 8'hFF, 23'b0}. Any other fraction with that exponent gives the quiet NaN {sign, 8'hFF, 1'b1, 22'b0}.
- R8: Bit 31 of the result always equals bit 7 of the input byte.
- R9: out_vld equals in_vld delayed by one clock. out_word takes the decode of the byte presented with in_vld=1, and holds its value while in_vld is low.
- R10: While rst_n is low, out_vld and out_word are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Input byte is valid |
| in_fmt | input | 1 | Layout select: 0 = 4-bit exponent, 1 = 5-bit exponent |
| in_byte | input | 8 | FP8 code |
| out_vld | output | 1 | Result valid, one clock after in_vld |
| out_word | output | 32 | Single-precision result |

## Verification
The hardest case to reach is the boundary between the two exponent-all-ones behaviours. The same byte is a large normal in one mode and a NaN in the other, and in the 4-bit layout only one fraction value of that exponent is special. The stimulus applies identical bytes such as 0x7C, 0x7E and 0x7F under both mode values and expects different results. It also runs every subnormal fraction, so that each leading-zero count from zero to two sets its own exponent. A sweep of all 512 byte and mode combinations then checks that the sign is carried through for every code.

// File: rtl/f8x_widen.sv
module f8x_widen (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_vld,
  input  logic        in_fmt,
  input  logic [7:0]  in_byte,
  output logic        out_vld,
  output logic [31:0] out_word
);

  logic       sgn;
  logic [4:0] ev;
  logic [2:0] mv;
  logic [7:0] eadj;
  logic       etop;
  logic [1:0] lz;
  logic [2:0] sfrac;
  logic [31:0] res;

  assign sgn  = in_byte[7];
  assign ev   = in_fmt ? in_byte[6:2] : {1'b0, in_byte[6:3]};
  assign mv   = in_fmt ? {in_byte[1:0], 1'b0} : in_byte[2:0];
  assign eadj = in_fmt ? 8'd112 : 8'd120;
  assign etop = in_fmt ? (&in_byte[6:2]) : (&in_byte[6:3]);

  assign lz    = mv[2] ? 2'd0 : (mv[1] ? 2'd1 : 2'd2);
  assign sfrac = mv[2] ? {mv[1:0], 1'b0} : (mv[1] ? {mv[0], 2'b00} : 3'b000);

  always_comb begin
    if (ev == 5'd0) begin
      if (mv == 3'd0) res = {sgn, 31'd0};
      else            res = {sgn, eadj - {6'd0, lz}, sfrac, 20'd0};
    end else if (etop && in_fmt && mv == 3'd0) begin
      res = {sgn, 8'hFF, 23'd0};
    end else if (etop && (in_fmt || mv == 3'b111)) begin
      res = {sgn, 8'hFF, 1'b1, 22'd0};
    end else begin
      res = {sgn, eadj + {3'd0, ev}, mv, 20'd0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_word <= 32'd0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) out_word <= res;
    end
  end

  a_r9_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);
  a_r9_vld_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);
  a_r9_word_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(out_word));
  a_r8_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_word[31] == $past(in_byte[7]));
  a_r5_zero_signed: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_byte[6:0] == 7'd0) |=> out_word[30:0] == 31'd0);
  a_r7_top_exp: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_fmt && in_byte[6:2] == 5'h1F) |=> out_word[30:23] == 8'hFF);
  a_r1_exp_span: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !in_fmt && in_byte[6:0] != 7'd0 && in_byte[6:0] != 7'h7F)
      |=> (out_word[30:23] >= 8'd118 && out_word[30:23] <= 8'd135));
  a_r2_exp_span: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_fmt && in_byte[6:0] != 7'd0 && in_byte[6:2] != 5'h1F)
      |=> (out_word[30:23] >= 8'd111 && out_word[30:23] <= 8'd142));

endmodule

// File: tb/f8x_widen_tb_top.sv
module f8x_widen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 30;

  // {req[3:0], fmt, byte[7:0], expected[31:0]}
  localparam logic [44:0] VEC [NV] = '{
    {4'd5,  1'b0, 8'h00, 32'h00000000},  // R5
    {4'd5,  1'b0, 8'h80, 32'h80000000},  // R5
    {4'd5,  1'b1, 8'h00, 32'h00000000},  // R5
    {4'd5,  1'b1, 8'h80, 32'h80000000},  // R5
    {4'd1,  1'b0, 8'h38, 32'h3F800000},  // R1
    {4'd1,  1'b0, 8'h78, 32'h43800000},  // R1
    {4'd1,  1'b0, 8'h08, 32'h3C800000},  // R1
    {4'd2,  1'b1, 8'h3C, 32'h3F800000},  // R2
    {4'd2,  1'b1, 8'h04, 32'h38800000},  // R2
    {4'd3,  1'b0, 8'h7E, 32'h43E00000},  // R3
    {4'd3,  1'b0, 8'hFE, 32'hC3E00000},  // R3
    {4'd3,  1'b1, 8'h7B, 32'h47600000},  // R3
    {4'd3,  1'b1, 8'hFB, 32'hC7600000},  // R3
    {4'd4,  1'b0, 8'h01, 32'h3B000000},  // R4
    {4'd4,  1'b0, 8'h02, 32'h3B800000},  // R4
    {4'd4,  1'b0, 8'h07, 32'h3C600000},  // R4
    {4'd4,  1'b0, 8'h85, 32'hBC200000},  // R4
    {4'd4,  1'b1, 8'h01, 32'h37800000},  // R4
    {4'd4,  1'b1, 8'h02, 32'h38000000},  // R4
    {4'd4,  1'b1, 8'h03, 32'h38400000},  // R4
    {4'd6,  1'b0, 8'h7F, 32'h7FC00000},  // R6
    {4'd6,  1'b0, 8'hFF, 32'hFFC00000},  // R6
    {4'd6,  1'b0, 8'h7C, 32'h43C00000},  // R6
    {4'd7,  1'b1, 8'h7C, 32'h7F800000},  // R7
    {4'd7,  1'b1, 8'hFC, 32'hFF800000},  // R7
    {4'd7,  1'b1, 8'h7D, 32'h7FC00000},  // R7
    {4'd7,  1'b1, 8'h7E, 32'h7FC00000},  // R7
    {4'd7,  1'b1, 8'hFF, 32'hFFC00000},  // R7
    {4'd7,  1'b1, 8'h7F, 32'h7FC00000},  // R7
    {4'd1,  1'b0, 8'hB8, 32'hBF800000}   // R1
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_vld = 1'b0;
  logic in_fmt = 1'b0;
  logic [7:0] in_byte = 8'd0;
  logic out_vld;
  logic [31:0] out_word;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  f8x_widen dut_i (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_fmt(in_fmt),
    .in_byte(in_byte), .out_vld(out_vld), .out_word(out_word)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic f, input logic [7:0] b);
    @(negedge clk);
    in_vld = 1'b1; in_fmt = f; in_byte = b;
    @(negedge clk);
    in_vld = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 3 + 2);
    // R10: reset state
    chk("R10", {31'd0, out_vld}, 32'd0);
    chk("R10", out_word, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][40], VEC[i][39:32]);
      chk($sformatf("R%0d", VEC[i][44:41]), out_word, VEC[i][31:0]);
      chk("R9", {31'd0, out_vld}, 32'd1);
    end

    // R9: word holds while in_vld low, out_vld drops
    drive(1'b0, 8'h38);
    in_byte = 8'h7E; in_fmt = 1'b1;
    @(negedge clk);
    chk("R9", {31'd0, out_vld}, 32'd0);
    chk("R9", out_word, 32'h3F800000);

    // R8: sign sweep over every code in both layouts
    for (int f = 0; f < 2; f++) begin
      for (int b = 0; b < 256; b++) begin
        drive(f[0], b[7:0]);
        chk("R8", {31'd0, out_word[31]}, {31'd0, b[7]});
      end
    end

    // R10: reset mid-stream clears outputs
    @(negedge clk);
    in_vld = 1'b1; in_byte = 8'h38; in_fmt = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R10", {31'd0, out_vld}, 32'd0);
    chk("R10", out_word, 32'd0);
    in_vld = 1'b0;
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule